// File: doc/BRIEF.md
# Banked Data RAM with Return-Address Stack

This block is the internal scratch RAM of a small 8-bit controller core. One flop-based byte array holds two working register banks of eight bytes each, a return-address stack of eight two-byte levels, and general data. The core reaches it through three paths that can all be active in the same cycle: a direct register port that names a register by bank and index, an indirect port that uses register 0 or 1 of the active bank as a byte pointer, and a push/pop port for 16-bit return addresses under a 3-bit stack pointer.

The regions overlap in one address space. Bank 0 is bytes 0 to 7, the stack is bytes 8 to 23, bank 1 is bytes 24 to 31, and everything above is free data. The stack bytes are ordinary RAM: any level not in use by call nesting can be read and written like any other location. The RAM size is a parameter with the legal values 64 and 128 bytes.

All reads return their data on the clock edge after the request. All reads see the contents from before any write made in the same cycle.

Top module: `core_dram`

## Requirements
- R1: After reset, every byte is 0, the stack pointer is 0, bank 0 is active, both read-data outputs and the popped address are 0, and `pop_valid` is low.
- R2: A direct access to register n (0..7) goes to address n when bank 0 is active and to address 24+n when bank 1 is active. Read data appears on `reg_rdata` one cycle after the request. The output holds its value in cycles with no direct read.
- R3: `bank_sel` is sampled on each clock edge. A direct access in the same cycle as a change still uses the old bank. Accesses from the following cycle onwards use the new bank.
- R4: An indirect access uses as its address the byte in register 0 (`ind_sel`=0) or register 1 (`ind_sel`=1) of the active bank. That byte is masked to the RAM size, so with 128 bytes the top pointer bit is ignored. Read data appears on `ind_rdata` one cycle later.
- R5: A push writes the low byte of `push_addr` to address 8+2*sp and the high byte to address 9+2*sp. The stack pointer then increments modulo 8, so a push at sp=7 writes bytes 22/23 and leaves sp=0.
- R6: A pop first decrements sp modulo 8. One cycle later it presents {byte 9+2*sp, byte 8+2*sp} of the new sp on `pop_addr`, with `pop_valid` high for that single cycle. A pop at sp=0 therefore reads level 7.
- R7: When push and pop are requested together, only the push happens: sp increments and `pop_valid` stays low.
- R8: A read and a write to the same address in the same cycle return the data from before the write.
- R9: Stack bytes act as ordinary RAM. Data written to an unused level through the indirect port survives pushes and pops to other levels.
- R10: When several ports write one address in the same cycle, the stack wins over the direct port, and the direct port wins over the indirect port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bank_sel | input | 1 | Requested register bank (0 or 1) |
| reg_en | input | 1 | Direct register access request |
| reg_we | input | 1 | Direct access is a write |
| reg_idx | input | 3 | Register number within the bank |
| reg_wdata | input | 8 | Direct write data |
| reg_rdata | output | 8 | Direct read data, one cycle latency |
| ind_en | input | 1 | Indirect access request |
| ind_we | input | 1 | Indirect access is a write |
| ind_sel | input | 1 | Pointer register select: 0 = register 0, 1 = register 1 |
| ind_wdata | input | 8 | Indirect write data |
| ind_rdata | output | 8 | Indirect read data, one cycle latency |
| push | input | 1 | Push a return address |
| pop | input | 1 | Pop a return address |
| push_addr | input | 16 | Return address to push |
| pop_addr | output | 16 | Popped return address |
| pop_valid | output | 1 | `pop_addr` holds a fresh pop result |
| stk_ptr | output | 3 | Current stack pointer |

## Verification
The bench builds the block with `MEM_BYTES` = 128, the larger of the two legal sizes. At this size the pointer mask matters. A pointer with bit 7 set must fold back into the lower 128 bytes, and a pointer of 0x45 must land above the 64-byte boundary and keep its data there. With 64 bytes neither case could be seen. The stack wrap at both ends, the push/pop collision, same-cycle read and write, and the write priority between ports are exercised the same way at either size.

// File: rtl/cdram_pkg.sv
`timescale 1ns/1ps
package cdram_pkg;
    localparam int BYTE_W     = 8;
    localparam int REG_IDX_W  = 3;
    localparam int SP_W       = 3;
    localparam int RET_BYTES  = 2;
    localparam int RET_W      = RET_BYTES * BYTE_W;
    localparam int BANK0_BASE = 0;
    localparam int BANK1_BASE = 24;
    localparam int STK_BASE   = 8;
endpackage

// File: rtl/cdram_regmap.sv
`timescale 1ns/1ps
// Maps a bank-relative register number and a pointer select to RAM addresses.
module cdram_regmap
    import cdram_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic                 bank,
    input  logic [REG_IDX_W-1:0] idx,
    input  logic                 ptr_sel,
    output logic [AW-1:0]        dir_addr,
    output logic [AW-1:0]        ptr_addr
);
    int base;

    always_comb begin
        base     = bank ? BANK1_BASE : BANK0_BASE;
        dir_addr = AW'(base + int'(idx));
        ptr_addr = AW'(base + int'(ptr_sel));
    end
endmodule

// File: rtl/cdram_stack.sv
`timescale 1ns/1ps
// Stack pointer update and the byte addresses of the levels touched by push/pop.
module cdram_stack
    import cdram_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic [SP_W-1:0] sp,
    input  logic            push,
    input  logic            pop,
    output logic [SP_W-1:0] sp_next,
    output logic            do_push,
    output logic            do_pop,
    output logic [AW-1:0]   wr_lo,
    output logic [AW-1:0]   wr_hi,
    output logic [AW-1:0]   rd_lo,
    output logic [AW-1:0]   rd_hi
);
    logic [SP_W-1:0] below;

    always_comb begin
        do_push = push;
        do_pop  = pop & ~push;          // push wins a collision
        below   = sp - SP_W'(1);
        if (do_push)     sp_next = sp + SP_W'(1);
        else if (do_pop) sp_next = below;
        else             sp_next = sp;
        wr_lo = AW'(STK_BASE + RET_BYTES * int'(sp));
        wr_hi = AW'(STK_BASE + RET_BYTES * int'(sp) + 1);
        rd_lo = AW'(STK_BASE + RET_BYTES * int'(below));
        rd_hi = AW'(STK_BASE + RET_BYTES * int'(below) + 1);
    end
endmodule

// File: rtl/core_dram.sv
`timescale 1ns/1ps
// Banked internal data RAM with an overlaid return-address stack.
module core_dram
    import cdram_pkg::*;
#(
    parameter int MEM_BYTES = 64
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bank_sel,
    input  logic                 reg_en,
    input  logic                 reg_we,
    input  logic [REG_IDX_W-1:0] reg_idx,
    input  logic [BYTE_W-1:0]    reg_wdata,
    output logic [BYTE_W-1:0]    reg_rdata,
    input  logic                 ind_en,
    input  logic                 ind_we,
    input  logic                 ind_sel,
    input  logic [BYTE_W-1:0]    ind_wdata,
    output logic [BYTE_W-1:0]    ind_rdata,
    input  logic                 push,
    input  logic                 pop,
    input  logic [RET_W-1:0]     push_addr,
    output logic [RET_W-1:0]     pop_addr,
    output logic                 pop_valid,
    output logic [SP_W-1:0]      stk_ptr
);
    localparam int AW = $clog2(MEM_BYTES);

    generate
        if (MEM_BYTES != 64 && MEM_BYTES != 128) begin : g_bad_size
            $error("core_dram: MEM_BYTES must be 64 or 128");
        end
    endgenerate

    typedef struct packed {
        logic [MEM_BYTES-1:0][BYTE_W-1:0] mem;
        logic [SP_W-1:0]                  sp;
        logic                             bank;
        logic [BYTE_W-1:0]                reg_rd;
        logic [BYTE_W-1:0]                ind_rd;
        logic [RET_W-1:0]                 pop_rd;
        logic                             pop_v;
    } state_t;

    state_t s_d, s_q;

    logic [AW-1:0]   dir_addr, ptr_addr, ind_addr;
    logic [AW-1:0]   wr_lo, wr_hi, rd_lo, rd_hi;
    logic [SP_W-1:0] sp_next;
    logic            do_push, do_pop;

    cdram_regmap #(.AW(AW)) u_map (
        .bank     (s_q.bank),
        .idx      (reg_idx),
        .ptr_sel  (ind_sel),
        .dir_addr (dir_addr),
        .ptr_addr (ptr_addr)
    );

    cdram_stack #(.AW(AW)) u_stk (
        .sp      (s_q.sp),
        .push    (push),
        .pop     (pop),
        .sp_next (sp_next),
        .do_push (do_push),
        .do_pop  (do_pop),
        .wr_lo   (wr_lo),
        .wr_hi   (wr_hi),
        .rd_lo   (rd_lo),
        .rd_hi   (rd_hi)
    );

    always_comb begin
        s_d       = s_q;
        s_d.bank  = bank_sel;
        s_d.sp    = sp_next;
        s_d.pop_v = 1'b0;

        // Pointer byte truncated to the address width: the size mask.
        ind_addr = AW'(s_q.mem[ptr_addr]);

        // Reads see the old contents.
        if (reg_en && !reg_we) s_d.reg_rd = s_q.mem[dir_addr];
        if (ind_en && !ind_we) s_d.ind_rd = s_q.mem[ind_addr];
        if (do_pop) begin
            s_d.pop_rd = {s_q.mem[rd_hi], s_q.mem[rd_lo]};
            s_d.pop_v  = 1'b1;
        end

        // Writes in rising priority: indirect, direct, stack.
        if (ind_en && ind_we) s_d.mem[ind_addr] = ind_wdata;
        if (reg_en && reg_we) s_d.mem[dir_addr] = reg_wdata;
        if (do_push) begin
            s_d.mem[wr_lo] = push_addr[BYTE_W-1:0];
            s_d.mem[wr_hi] = push_addr[RET_W-1:BYTE_W];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign reg_rdata = s_q.reg_rd;
    assign ind_rdata = s_q.ind_rd;
    assign pop_addr  = s_q.pop_rd;
    assign pop_valid = s_q.pop_v;
    assign stk_ptr   = s_q.sp;
endmodule

// File: rtl/cdram_chk.sv
`timescale 1ns/1ps
module cdram_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       push,
    input logic       pop,
    input logic       reg_en,
    input logic       reg_we,
    input logic [7:0] reg_rdata,
    input logic [2:0] stk_ptr,
    input logic       pop_valid
);
    p_push_inc_r5: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> stk_ptr == 3'($past(stk_ptr) + 3'd1));

    p_pop_dec_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push) |=> (stk_ptr == 3'($past(stk_ptr) - 3'd1)) && pop_valid);

    p_collide_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop) |=> !pop_valid);

    p_sp_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!push && !pop) |=> $stable(stk_ptr) && !pop_valid);

    p_rd_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_en && !reg_we) |=> $stable(reg_rdata));
endmodule

bind core_dram cdram_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push),
    .pop       (pop),
    .reg_en    (reg_en),
    .reg_we    (reg_we),
    .reg_rdata (reg_rdata),
    .stk_ptr   (stk_ptr),
    .pop_valid (pop_valid)
);

// File: tb/sim_core_dram.sv
`timescale 1ns/1ps
module sim_core_dram;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bank_sel = 1'b0;
    logic        reg_en = 1'b0, reg_we = 1'b0;
    logic [2:0]  reg_idx = '0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        ind_en = 1'b0, ind_we = 1'b0, ind_sel = 1'b0;
    logic [7:0]  ind_wdata = '0;
    logic [7:0]  ind_rdata;
    logic        push = 1'b0, pop = 1'b0;
    logic [15:0] push_addr = '0;
    logic [15:0] pop_addr;
    logic        pop_valid;
    logic [2:0]  stk_ptr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [7:0]  d;
    logic [15:0] w;
    logic        v;

    always #2 clk = ~clk;

    core_dram #(.MEM_BYTES(128)) u0 (
        .clk(clk), .rst_n(rst_n), .bank_sel(bank_sel),
        .reg_en(reg_en), .reg_we(reg_we), .reg_idx(reg_idx),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ind_en(ind_en), .ind_we(ind_we), .ind_sel(ind_sel),
        .ind_wdata(ind_wdata), .ind_rdata(ind_rdata),
        .push(push), .pop(pop), .push_addr(push_addr),
        .pop_addr(pop_addr), .pop_valid(pop_valid), .stk_ptr(stk_ptr)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic dwr(input logic [2:0] i, input logic [7:0] x);
        reg_en = 1; reg_we = 1; reg_idx = i; reg_wdata = x;
        @(negedge clk);
        reg_en = 0; reg_we = 0;
    endtask

    task automatic drd(input logic [2:0] i, output logic [7:0] x);
        reg_en = 1; reg_we = 0; reg_idx = i;
        @(negedge clk);
        reg_en = 0;
        x = reg_rdata;
    endtask

    task automatic iwr(input logic s, input logic [7:0] x);
        ind_en = 1; ind_we = 1; ind_sel = s; ind_wdata = x;
        @(negedge clk);
        ind_en = 0; ind_we = 0;
    endtask

    task automatic ird(input logic s, output logic [7:0] x);
        ind_en = 1; ind_we = 0; ind_sel = s;
        @(negedge clk);
        ind_en = 0;
        x = ind_rdata;
    endtask

    task automatic set_bank(input logic b);
        bank_sel = b;
        @(negedge clk);
    endtask

    // Reads any byte through bank-0 register 0 (clobbers it).
    task automatic peek(input logic [7:0] a, output logic [7:0] x);
        dwr(3'd0, a);
        ird(1'b0, x);
    endtask

    task automatic do_push(input logic [15:0] a);
        push = 1; push_addr = a;
        @(negedge clk);
        push = 0;
    endtask

    task automatic do_pop(output logic [15:0] a, output logic vv);
        pop = 1;
        @(negedge clk);
        pop = 0;
        a = pop_addr; vv = pop_valid;
    endtask

    task automatic t_reset();
        chk("R1 reg_rdata", 16'(reg_rdata), 16'h0);
        chk("R1 ind_rdata", 16'(ind_rdata), 16'h0);
        chk("R1 pop_valid", 16'(pop_valid), 16'h0);
        chk("R1 pop_addr", pop_addr, 16'h0);
        chk("R1 stk_ptr", 16'(stk_ptr), 16'h0);
        drd(3'd5, d);
        chk("R1 byte 5 zero", 16'(d), 16'h0);
    endtask

    task automatic t_banks();
        dwr(3'd3, 8'hA5);
        set_bank(1'b1);
        dwr(3'd3, 8'h5A);
        drd(3'd3, d);
        chk("R2 bank1 r3", 16'(d), 16'h5A);
        set_bank(1'b0);
        drd(3'd3, d);
        chk("R2 bank0 r3", 16'(d), 16'hA5);
        dwr(3'd1, 8'd27);
        ird(1'b1, d);
        chk("R2 bank1 at 24+3", 16'(d), 16'h5A);
        dwr(3'd0, 8'd3);
        ird(1'b0, d);
        chk("R2 bank0 at 3", 16'(d), 16'hA5);
        @(negedge clk);
        chk("R2 rdata holds", 16'(reg_rdata), 16'hA5);
    endtask

    task automatic t_bank_timing();
        bank_sel = 1; reg_en = 1; reg_we = 0; reg_idx = 3'd3;
        @(negedge clk);
        chk("R3 same-cycle old bank", 16'(reg_rdata), 16'hA5);
        @(negedge clk);
        reg_en = 0;
        chk("R3 next-cycle new bank", 16'(reg_rdata), 16'h5A);
        set_bank(1'b0);
    endtask

    task automatic t_mask();
        dwr(3'd0, 8'hC5);
        iwr(1'b0, 8'h3C);
        dwr(3'd1, 8'h45);
        ird(1'b1, d);
        chk("R4 top bit masked", 16'(d), 16'h3C);
        dwr(3'd5, 8'h6B);
        dwr(3'd1, 8'h85);
        ird(1'b1, d);
        chk("R4 0x85 -> 5", 16'(d), 16'h6B);
        set_bank(1'b1);
        dwr(3'd0, 8'h45);
        ird(1'b0, d);
        chk("R4 bank1 pointer", 16'(d), 16'h3C);
        set_bank(1'b0);
    endtask

    task automatic t_push_pop();
        do_push(16'h1234);
        chk("R5 sp after push", 16'(stk_ptr), 16'd1);
        do_push(16'hBEEF);
        chk("R5 sp after 2 push", 16'(stk_ptr), 16'd2);
        peek(8'd8, d);  chk("R5 byte8 low", 16'(d), 16'h34);
        peek(8'd9, d);  chk("R5 byte9 high", 16'(d), 16'h12);
        peek(8'd10, d); chk("R5 byte10", 16'(d), 16'hEF);
        peek(8'd11, d); chk("R5 byte11", 16'(d), 16'hBE);
        do_pop(w, v);
        chk("R6 pop data", w, 16'hBEEF);
        chk("R6 pop valid", 16'(v), 16'h1);
        chk("R6 sp after pop", 16'(stk_ptr), 16'd1);
        @(negedge clk);
        chk("R6 valid one cycle", 16'(pop_valid), 16'h0);
        do_pop(w, v);
        chk("R6 second pop", w, 16'h1234);
        chk("R6 sp back to 0", 16'(stk_ptr), 16'd0);
    endtask

    task automatic t_wrap();
        dwr(3'd0, 8'd22); iwr(1'b0, 8'h77);
        dwr(3'd0, 8'd23); iwr(1'b0, 8'h66);
        do_pop(w, v);
        chk("R6 pop at 0 wraps sp", 16'(stk_ptr), 16'd7);
        chk("R6 pop at 0 reads level 7", w, 16'h6677);
        do_push(16'hCAFE);
        chk("R5 push at 7 wraps sp", 16'(stk_ptr), 16'd0);
        peek(8'd22, d); chk("R5 level7 low", 16'(d), 16'hFE);
        peek(8'd23, d); chk("R5 level7 high", 16'(d), 16'hCA);
    endtask

    task automatic t_collide();
        push = 1; pop = 1; push_addr = 16'h0F0E;
        @(negedge clk);
        push = 0; pop = 0;
        chk("R7 no pop_valid", 16'(pop_valid), 16'h0);
        chk("R7 sp incremented", 16'(stk_ptr), 16'd1);
        peek(8'd8, d); chk("R7 push written", 16'(d), 16'h0E);
        do_pop(w, v);
        chk("R7 pushed value pops", w, 16'h0F0E);
    endtask

    task automatic t_rbw();
        dwr(3'd2, 8'h99);
        dwr(3'd0, 8'd2);
        reg_en = 1; reg_we = 1; reg_idx = 3'd2; reg_wdata = 8'h11;
        ind_en = 1; ind_we = 0; ind_sel = 0;
        @(negedge clk);
        reg_en = 0; reg_we = 0; ind_en = 0;
        chk("R8 old data read", 16'(ind_rdata), 16'h99);
        ird(1'b0, d);
        chk("R8 new data later", 16'(d), 16'h11);
    endtask

    task automatic t_stack_ram();
        dwr(3'd0, 8'd20);
        iwr(1'b0, 8'hD4);
        do_push(16'h5555);
        do_push(16'h6666);
        do_pop(w, v);
        do_pop(w, v);
        ird(1'b0, d);
        chk("R9 unused level keeps data", 16'(d), 16'hD4);
    endtask

    task automatic t_priority();
        dwr(3'd0, 8'd4);
        reg_en = 1; reg_we = 1; reg_idx = 3'd4; reg_wdata = 8'h44;
        ind_en = 1; ind_we = 1; ind_sel = 0; ind_wdata = 8'h55;
        @(negedge clk);
        reg_en = 0; reg_we = 0; ind_en = 0; ind_we = 0;
        drd(3'd4, d);
        chk("R10 direct over indirect", 16'(d), 16'h44);
        dwr(3'd1, 8'd8);
        push = 1; push_addr = 16'hABCD;
        ind_en = 1; ind_we = 1; ind_sel = 1; ind_wdata = 8'h99;
        @(negedge clk);
        push = 0; ind_en = 0; ind_we = 0;
        peek(8'd8, d);
        chk("R10 stack over indirect", 16'(d), 16'hCD);
        do_pop(w, v);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_banks();
        t_bank_timing();
        t_mask();
        t_push_pop();
        t_wrap();
        t_collide();
        t_rbw();
        t_stack_ram();
        t_priority();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule